// File: doc/BRIEF.md
# Shared-Count Ramp Digitizer Back End

This block is the digital half of a single-ramp converter that digitizes a whole row of analog storage cells in one pass. A start pulse clears a single 12-bit counter and sets it running. The counter runs in step with a common analog ramp that is shared by every cell. Each cell has its own comparator. When that comparator switches, the cell stores the counter value of that moment in its own register. The stored value is the cell's code. All cells are converted together in one run of the counter.

Every comparator input is synchronized to the conversion clock before its rising edge is detected. The counter is shared, and each cell holds only local state, so no combinational path runs from one cell to another. This matters because the conversion clock can be very fast. A run ends after the counter has stepped through the full scale. At that point every cell that has not yet captured a value is forced to the full-scale code, and done is pulsed for one cycle. The codes are presented as parallel registers that hold until the next start. They are not streamed, so the outputs have no handshake, and a reader may sample them at any time after done.

Top module: `wk_conv_array`

## Requirements
- R1: After reset, done is 0, every valid flag is 0 and every code is 0.
- R2: A start seen while the block is idle clears all codes and valid flags on that same edge, loads the count with 0, and the count then advances by one on each clock edge.
- R3: Let n be the number of clock edges from the start edge to the first edge at which a cell's comparator is sampled high after having been low. That cell's code becomes n+1, which accounts for the two synchronizer flops and the edge detector, and its valid flag rises.
- R4: Only the first rising comparator edge after start is captured. Later falls and rises of the same comparator leave the code unchanged.
- R5: A cell whose comparator never rises during the run, or whose rise would yield a value above 4095, gets code 4095 with its valid flag set.
- R6: done is high for exactly one cycle, following the 4096th clock edge after the start edge, and all valid flags are set while it is high.
- R7: After done the counter stops. Codes and valid flags hold and done does not repeat until the next start.
- R8: A start that arrives while a conversion is running is ignored. It neither clears captured codes nor moves the end of the run.
- R9: A comparator that is already high when start arrives produces no rising edge and therefore receives code 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion; ignored while one is running |
| cmp_in | input | NCELLS | One comparator output per cell, asynchronous |
| code_flat | output | NCELLS*CW | Captured codes; cell c occupies bits c*CW upward |
| code_valid | output | NCELLS | Per-cell capture flag |
| done | output | 1 | One-cycle pulse at the end of a conversion |

## Verification
A directed run spreads comparator rises evenly across the ramp and places cells at the first possible cycle, just below full scale, just above full scale, and never. This shows the exact capture latency and where full-scale clamping begins. Random runs with a fixed seed mix in three further cases. Comparators that bounce after their first rise separate first-edge capture from last-edge capture. Comparators held high across start show that a level is not taken for an edge. A second start fired in the middle of a run shows whether it is ignored or restarts the counter. Each run also checks the exact cycle of done and that nothing moves after it.

// File: rtl/wk_pkg.sv
package wk_pkg;
  // control bundle broadcast from the shared counter to every cell
  typedef struct packed {
    logic clr;  // a new conversion begins on this edge
    logic run;  // counter is stepping
    logic fin;  // last count of the run is present
  } wk_ctl_t;
endpackage

// File: rtl/wk_counter.sv
module wk_counter
  import wk_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [CW-1:0] count,
  output wk_ctl_t       ctl,
  output logic          done
);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic running;
  logic clr, fin;

  assign clr = start & ~running;
  assign fin = running & (count == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= fin;
      if (clr) begin
        count   <= '0;
        running <= 1'b1;
      end else if (running) begin
        count <= count + 1'b1;
        if (fin) running <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.clr = clr;
    ctl.run = running;
    ctl.fin = fin;
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fin_raises_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done && !running));
  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fin) |=> (count == $past(count) + 1'b1));
  assert_count_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && running && !fin) |=> (running && count != '0));
endmodule

// File: rtl/wk_edge_sync.sv
module wk_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic meta, sync, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      sync <= 1'b0;
      prev <= 1'b0;
    end else begin
      meta <= din;
      sync <= meta;
      prev <= sync;
    end
  end

  assign rise = sync & ~prev;
endmodule

// File: rtl/wk_cell.sv
module wk_cell
  import wk_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  wk_ctl_t       ctl,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] code,
  output logic          valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      valid <= 1'b0;
    end else if (ctl.clr) begin
      code  <= '0;
      valid <= 1'b0;
    end else if (ctl.run && !valid && (rise || ctl.fin)) begin
      code  <= count;   // equals full scale when forced by fin
      valid <= 1'b1;
    end
  end

  assert_first_edge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ctl.clr) |=> (valid && $stable(code)));
  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> (!valid && code == '0));
  assert_forced_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.fin && !valid) |=> (valid && (&code)));
endmodule

// File: rtl/wk_conv_array.sv
module wk_conv_array
  import wk_pkg::*;
#(
  parameter int NCELLS = 256,
  parameter int CW     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NCELLS-1:0]    cmp_in,
  output logic [NCELLS*CW-1:0] code_flat,
  output logic [NCELLS-1:0]    code_valid,
  output logic                 done
);
  logic [CW-1:0] count;
  wk_ctl_t       ctl;

  wk_counter #(.CW(CW)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .count (count),
    .ctl   (ctl),
    .done  (done)
  );

  for (genvar c = 0; c < NCELLS; c++) begin : g_cell
    logic rise;

    wk_edge_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cmp_in[c]),
      .rise  (rise)
    );

    wk_cell #(.CW(CW)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .rise  (rise),
      .ctl   (ctl),
      .count (count),
      .code  (code_flat[c*CW +: CW]),
      .valid (code_valid[c])
    );
  end

  assert_all_valid_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&code_valid));
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done));
endmodule

// File: tb/wk_conv_array_bench.sv
module wk_conv_array_bench;
  localparam int NC   = 256;
  localparam int CW   = 12;
  localparam int FULL = 4095;
  localparam int LAST = 4120;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [NC-1:0]      cmp_in = '0;
  logic [NC*CW-1:0]   code_flat;
  logic [NC-1:0]      code_valid;
  logic               done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  int rise_at [NC];
  bit bounce  [NC];
  bit pre_hi  [NC];

  wk_conv_array #(.NCELLS(NC), .CW(CW)) u_wk_conv_array (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .code_flat(code_flat), .code_valid(code_valid), .done(done)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cycles++;

  function automatic int exp_code(int r);
    if (r < 0) return FULL;
    if (r + 2 > FULL) return FULL;
    return r + 2;
  endfunction

  function automatic bit cmp_level(int c, int cyc);
    if (pre_hi[c]) return 1'b1;
    if (rise_at[c] < 0) return 1'b0;
    if (cyc < rise_at[c]) return 1'b0;
    if (bounce[c] && cyc >= rise_at[c] + 5 && cyc < rise_at[c] + 10) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_conv(bit mid_start);
    int done_err = 0;
    int first_bad = -1;
    for (int c = 0; c < NC; c++) cmp_in[c] = pre_hi[c];
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: flags cleared by start
    check(code_valid == '0, "R2 valid cleared", $countones(code_valid), 0);
    for (int cyc = 0; cyc <= LAST; cyc++) begin
      if (done !== (cyc == 4096)) begin
        done_err++;
        if (first_bad < 0) first_bad = cyc;
      end
      for (int c = 0; c < NC; c++) cmp_in[c] = cmp_level(c, cyc);
      start = (mid_start && cyc == 1000);
      @(negedge clk);
    end
    start = 1'b0;
    // R6 / R7: single done at edge 4096, never again
    check(done_err == 0, "R6 R7 done timing", first_bad, 4096);
    for (int c = 0; c < NC; c++) begin
      int e = exp_code(pre_hi[c] ? -1 : rise_at[c]);
      int a = int'(code_flat[c*CW +: CW]);
      check(code_valid[c] && a == e,
            mid_start ? "R3 R4 R5 R8 R9 code" : "R3 R4 R5 R9 code", a, e);
    end
    cmp_in = '0;
    repeat (5) @(negedge clk);
    // R7: held after run
    check(&code_valid, "R7 valid hold", $countones(code_valid), NC);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done", done, 0);
    check(code_valid == '0, "R1 valid", $countones(code_valid), 0);
    check(code_flat == '0, "R1 codes", (code_flat == '0) ? 0 : 1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed: even spread plus boundaries
    for (int c = 0; c < NC; c++) begin
      rise_at[c] = c * 16; bounce[c] = 0; pre_hi[c] = 0;
    end
    rise_at[253] = 4092;  // R3 code 4094
    rise_at[254] = 4093;  // R5 clamps to 4095
    rise_at[255] = -1;    // R5 never
    run_conv(1'b0);

    // random with bounces and pre-high cells
    for (int c = 0; c < NC; c++) begin
      int k = $urandom_range(0, 9);
      rise_at[c] = (k == 0) ? -1 : int'($urandom_range(0, 4200));
      bounce[c]  = (k >= 6);
      pre_hi[c]  = (k == 1);
    end
    run_conv(1'b0);

    // random with a mid-run start (R8)
    for (int c = 0; c < NC; c++) begin
      int k = $urandom_range(0, 9);
      rise_at[c] = (k == 0) ? -1 : int'($urandom_range(0, 4200));
      bounce[c]  = (k >= 7);
      pre_hi[c]  = 0;
    end
    rise_at[0] = 10;  // captured before the stray start, must survive
    run_conv(1'b1);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule